// File: doc/BRIEF.md
# SPI Slave with Reselect-Gated Transmit

This block is an SPI slave shift engine for 8-bit frames in clock mode 0. The serial clock, data-in and active-low select pins are brought into a faster system clock through synchronisers, and all bus activity is decoded from edges seen in that domain. Software loads a transmit register through a simple write port. Each completed frame is presented on a parallel output together with a one-cycle valid strobe.

What goes out on MISO depends on how the frame began. If select was released for at least a programmable number of system clocks before it was asserted again, the frame sends the transmit register. If select stayed low across frames, or was only released briefly, the frame sends back the byte received in the frame before it. This lets a master stream continuously and get an echo of its own data, or reselect cleanly to fetch fresh data. A status output reports which of the two sources fed the current frame.

Top module: `spi_echo_slave`

## Requirements
- R1: MOSI is sampled on each rising SCK edge while select is low, MSB first. After every eighth rising edge the assembled byte appears on `rx_data_o`, and `rx_valid_o` is high for exactly one system clock.
- R2: MISO sends the loaded byte MSB first. The first bit is valid before the first rising SCK edge after select is asserted, and the bit advances on each falling SCK edge. `miso_oe_o` is 1 while a frame is loaded.
- R3: The first frame after reset sends the transmit register, and `tx_from_reg_o` reads 1 during that frame.
- R4: A frame that follows another frame with select held low sends the byte received in that previous frame, and `tx_from_reg_o` reads 0. The same applies when select was released for fewer than `idle_min_i` synchronised system clocks.
- R5: When select is released for at least `idle_min_i` system clocks, the next frame sends the transmit register and `tx_from_reg_o` reads 1. The threshold is taken from the port, so changing it moves the boundary.
- R6: Asserting select realigns the bit counter. A frame cut short by a brief release is discarded, and the next eight rising edges form a complete new byte.
- R7: While select is high, SCK and MOSI have no effect: no `rx_valid_o` pulse occurs, `miso_oe_o` is 0 and `miso_o` is 0.
- R8: `tx_wr_i` loads `tx_data_i` into the transmit register. A write made while select is low between streamed frames does not replace the echo in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master (idle low) |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| idle_min_i | input | IDLE_W | Minimum select-high time, in system clocks, that re-arms the transmit register |
| tx_wr_i | input | 1 | Write strobe for the transmit register |
| tx_data_i | input | FRAME_W | Transmit register write data |
| miso_o | output | 1 | Serial data to the master (0 when not enabled) |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| rx_data_o | output | FRAME_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe when a byte completes |
| tx_from_reg_o | output | 1 | 1 when the current frame came from the transmit register, 0 when it is an echo |

## Verification
The bench sweeps the select-high time from one clock up to a few clocks past the threshold, for two thresholds. It checks that the source flips exactly at `idle_min_i`. An off-by-one in the idle counter would move that boundary. A design that re-armed on any release would send the register after a one-clock glitch. Other runs cover:
- a long stream of echoed frames, where a wrong reload would send shifted or stale bytes;
- SCK toggling while deselected, which a design that did not gate on select would count as data;
- a frame cut off after three bits, which, without realignment, would merge into the next byte.

// File: rtl/spi_echo_pkg.sv
package spi_echo_pkg;

    // Source of the byte loaded into the transmit shifter
    typedef enum logic {
        SRC_ECHO  = 1'b0,
        SRC_TXREG = 1'b1
    } tx_src_e;

endpackage

// File: rtl/spi_echo_sync.sv
module spi_echo_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_echo_idle.sv
module spi_echo_idle #(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,      // synchronised select, 1 = released
    input  logic [IDLE_W-1:0] idle_min,
    input  logic              consume,   // frame start took the register
    output logic              armed
);

    typedef struct packed {
        logic [IDLE_W-1:0] cnt;
        logic              armed;
    } idle_state_t;

    idle_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ss_s) begin
            if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_d.cnt >= idle_min) begin
                st_d.armed = 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        if (consume) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;   // first frame after reset sends the register
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/spi_echo_core.sv
module spi_echo_core
    import spi_echo_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               ss_s,
    input  logic               armed,
    input  logic               tx_wr,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               consume,
    output logic               miso,
    output logic               miso_oe,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_valid,
    output logic               tx_from_reg
);

    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] tx_reg;
        logic [FRAME_W-1:0] shift;
        logic [FRAME_W-1:0] rx_shift;
        logic [FRAME_W-1:0] rx_data;
        logic [BIT_W-1:0]   bitcnt;
        logic               reload;
        logic               rx_valid;
        logic               oe;
        tx_src_e            src;
        logic               sck_prev;
        logic               ss_prev;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        sck_rise, sck_fall;

    assign sck_rise = sck_s & ~st_q.sck_prev;
    assign sck_fall = ~sck_s & st_q.sck_prev;

    always_comb begin
        st_d          = st_q;
        consume       = 1'b0;
        st_d.rx_valid = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.ss_prev  = ss_s;

        if (tx_wr) begin
            st_d.tx_reg = tx_data;
        end

        if (ss_s) begin
            // deselected: bus ignored, counter held at a byte boundary
            st_d.oe     = 1'b0;
            st_d.bitcnt = '0;
            st_d.reload = 1'b0;
        end else if (st_q.ss_prev) begin
            // select just asserted: start a new frame
            st_d.shift  = armed ? st_q.tx_reg : st_q.rx_data;
            st_d.src    = armed ? SRC_TXREG : SRC_ECHO;
            consume     = armed;
            st_d.bitcnt = '0;
            st_d.reload = 1'b0;
            st_d.oe     = 1'b1;
        end else begin
            if (sck_rise) begin
                st_d.rx_shift = {st_q.rx_shift[FRAME_W-2:0], mosi_s};
                if (st_q.bitcnt == LAST_BIT) begin
                    st_d.rx_data  = {st_q.rx_shift[FRAME_W-2:0], mosi_s};
                    st_d.rx_valid = 1'b1;
                    st_d.bitcnt   = '0;
                    st_d.reload   = 1'b1;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end
            if (sck_fall) begin
                if (st_q.reload) begin
                    // back-to-back frame: next byte loaded on the closing edge
                    st_d.shift  = armed ? st_q.tx_reg : st_q.rx_data;
                    st_d.src    = armed ? SRC_TXREG : SRC_ECHO;
                    consume     = armed;
                    st_d.reload = 1'b0;
                end else begin
                    st_d.shift = {st_q.shift[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tx_reg   <= '0;
            st_q.shift    <= '0;
            st_q.rx_shift <= '0;
            st_q.rx_data  <= '0;
            st_q.bitcnt   <= '0;
            st_q.reload   <= 1'b0;
            st_q.rx_valid <= 1'b0;
            st_q.oe       <= 1'b0;
            st_q.src      <= SRC_ECHO;
            st_q.sck_prev <= 1'b0;
            st_q.ss_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso        = st_q.oe & st_q.shift[FRAME_W-1];
    assign miso_oe     = st_q.oe;
    assign rx_data     = st_q.rx_data;
    assign rx_valid    = st_q.rx_valid;
    assign tx_from_reg = (st_q.src == SRC_TXREG);

endmodule

// File: rtl/spi_echo_slave.sv
module spi_echo_slave #(
    parameter int FRAME_W     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_i,
    input  logic               mosi_i,
    input  logic               ss_n_i,
    input  logic [IDLE_W-1:0]  idle_min_i,
    input  logic               tx_wr_i,
    input  logic [FRAME_W-1:0] tx_data_i,
    output logic               miso_o,
    output logic               miso_oe_o,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               rx_valid_o,
    output logic               tx_from_reg_o
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_sync;
    logic             ss_sync, sck_sync, mosi_sync;
    logic             armed, consume;

    spi_echo_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ss_n_i, sck_i, mosi_i}),
        .sync_o  (pins_sync)
    );

    assign {ss_sync, sck_sync, mosi_sync} = pins_sync;

    spi_echo_idle #(
        .IDLE_W (IDLE_W)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_s     (ss_sync),
        .idle_min (idle_min_i),
        .consume  (consume),
        .armed    (armed)
    );

    spi_echo_core #(
        .FRAME_W (FRAME_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_sync),
        .mosi_s      (mosi_sync),
        .ss_s        (ss_sync),
        .armed       (armed),
        .tx_wr       (tx_wr_i),
        .tx_data     (tx_data_i),
        .consume     (consume),
        .miso        (miso_o),
        .miso_oe     (miso_oe_o),
        .rx_data     (rx_data_o),
        .rx_valid    (rx_valid_o),
        .tx_from_reg (tx_from_reg_o)
    );

endmodule

// File: rtl/spi_echo_slave_chk.sv
module spi_echo_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_s,
    input logic armed,
    input logic rx_valid,
    input logic tx_from_reg
);

    // R1
    rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    no_rx_while_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !rx_valid);

    // R3
    reg_source_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_from_reg) |-> $past(armed));

    // R5
    arm_only_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_s |=> !$rose(armed));

    // R5
    arm_held_while_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ss_s) |=> armed);

endmodule

bind spi_echo_slave spi_echo_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_s        (ss_sync),
    .armed       (armed),
    .rx_valid    (rx_valid_o),
    .tx_from_reg (tx_from_reg_o)
);

// File: tb/spi_echo_slave_bench.sv
module spi_echo_slave_bench;

    localparam int HALF = 6;   // SCK half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic [7:0] idle_min = 8'd8;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       miso, miso_oe, rx_valid, tx_from_reg;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = '0;

    always #5 clk = ~clk;

    spi_echo_slave u_spi_echo_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_i         (sck),
        .mosi_i        (mosi),
        .ss_n_i        (ss_n),
        .idle_min_i    (idle_min),
        .tx_wr_i       (tx_wr),
        .tx_data_i     (tx_data),
        .miso_o        (miso),
        .miso_oe_o     (miso_oe),
        .rx_data_o     (rx_data),
        .rx_valid_o    (rx_valid),
        .tx_from_reg_o (tx_from_reg)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_data;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_tx(input logic [7:0] v);
        tx_data = v;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic shift_bits(input logic [7:0] m, input int nbits,
                              output logic [7:0] s, output logic src,
                              output logic oe);
        s = '0; src = 1'b0; oe = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = m[7-i];
            repeat (HALF) @(negedge clk);
            s = {s[6:0], miso};
            if (i == 0) begin
                src = tx_from_reg;
                oe  = miso_oe;
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic deselect(input int n);
        ss_n = 1'b1;
        repeat (n) @(negedge clk);
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, prev, m, tx;
        logic       src, oe;
        int         exp_cnt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R7", "reset miso_oe", {7'd0, miso_oe}, 8'd0);
        check("R1", "reset rx_valid", {7'd0, rx_valid}, 8'd0);
        check("R3", "reset tx_from_reg", {7'd0, tx_from_reg}, 8'd0);
        check("R1", "reset rx_data", rx_data, 8'd0);

        // R3: first frame after reset sends the register
        write_tx(8'hA5);
        repeat (10) @(negedge clk);
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        shift_bits(8'h3C, 8, s, src, oe);
        check("R3", "first frame miso", s, 8'hA5);
        check("R3", "first frame source", {7'd0, src}, 8'd1);
        check("R2", "miso_oe during frame", {7'd0, oe}, 8'd1);
        check("R1", "rx byte", rx_last, 8'h3C);
        check("R1", "rx pulse count", rx_cnt[7:0], 8'd1);
        exp_cnt = 1;
        prev = 8'h3C;

        // R4: streamed frames echo the previous byte; R8: write between them
        for (int k = 0; k < 8; k++) begin
            m = 8'(k * 37 + 11);
            if (k == 3) write_tx(8'hEE);
            shift_bits(m, 8, s, src, oe);
            exp_cnt++;
            check("R4", "stream echo miso", s, prev);
            check("R4", "stream source", {7'd0, src}, 8'd0);
            check("R1", "stream rx byte", rx_last, m);
            if (k == 4) check("R8", "write while low keeps echo", s, prev);
            prev = m;
        end
        check("R1", "stream rx pulses", rx_cnt[7:0], 8'(exp_cnt));

        // R5 / R4: sweep select-high time across two thresholds
        for (int t = 0; t < 2; t++) begin
            idle_min = (t == 0) ? 8'd3 : 8'd8;
            for (int n = 1; n <= int'(idle_min) + 3; n++) begin
                tx = 8'(n * 29 + t * 101 + 7);
                write_tx(tx);
                deselect(n);
                m = 8'(n * 13 + t * 71 + 5);
                shift_bits(m, 8, s, src, oe);
                if (n >= int'(idle_min)) begin
                    check("R5", "armed frame miso", s, tx);
                    check("R5", "armed source", {7'd0, src}, 8'd1);
                end else begin
                    check("R4", "short release echo miso", s, prev);
                    check("R4", "short release source", {7'd0, src}, 8'd0);
                end
                check("R1", "sweep rx byte", rx_last, m);
                prev = m;
            end
        end

        // R7: bus ignored while deselected
        ss_n = 1'b1;
        repeat (20) @(negedge clk);
        exp_cnt = rx_cnt;
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            sck  = 1'b1;
            repeat (HALF) @(negedge clk);
            check("R7", "miso_oe while high", {7'd0, miso_oe}, 8'd0);
            check("R7", "miso while high", {7'd0, miso}, 8'd0);
            sck  = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        check("R7", "no rx pulse while high", rx_cnt[7:0], 8'(exp_cnt));
        write_tx(8'h5A);
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        shift_bits(8'hC3, 8, s, src, oe);
        check("R7", "byte after ignored clocks", rx_last, 8'hC3);
        check("R5", "register after long release", s, 8'h5A);
        prev = 8'hC3;

        // R6: partial frame then brief reselect realigns
        exp_cnt = rx_cnt;
        shift_bits(8'hFF, 3, s, src, oe);
        deselect(1);
        shift_bits(8'h96, 8, s, src, oe);
        check("R6", "realigned rx byte", rx_last, 8'h96);
        check("R6", "one pulse for cut frame pair", rx_cnt[7:0], 8'(exp_cnt + 1));
        check("R6", "echo after glitch", s, prev);

        ss_n = 1'b1;
        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule